// File: doc/BRIEF.md
# DMA Address Translation Table Walker

This block turns an inbound DMA address into a system address. It looks up a window descriptor for the request, and the descriptor says how to translate. The walker then reads a tree of translation entries from memory one level at a time, or it skips the tree in bypass mode. It returns the page-aligned system address, the page mask and the read/write permission. When a check fails it returns a fault code instead.

Before any table access the block steers the request. Addresses in message-interrupt regions are rejected, and addresses in unsupported regions are rejected too. The descriptor index, formed from the partition number and one address bit, goes out on `desc_idx`. The descriptor comes back on `desc_data` in the same cycle. The walker keeps one 8-byte read outstanding on the memory port. Table entries arrive in big-endian byte order.

The state machine has six states:

- `S_IDLE` accepts a request. It goes to `S_FAULT` on a rejection, to `S_DONE` for bypass, and otherwise to `S_READ`.
- `S_READ` holds the read request until `mem_req_ready`, then goes to `S_WAIT`.
- `S_WAIT` waits for a response. An error response goes to `S_FAULT`; otherwise it goes to `S_CHECK`.
- `S_CHECK` handles an intermediate entry by going back to `S_READ`, or to `S_FAULT` if the entry is invalid. It handles the final entry by going to `S_DONE`, or to `S_FAULT` on a permission mismatch.
- `S_DONE` and `S_FAULT` each last one cycle, then return to `S_IDLE`.

Top module: `dma_xlate_walker`

## Requirements
- R1: When address bits [63:60] equal 1 the request ends with fault code 2. When they are any value other than 0 or 1 it ends with fault code 3. In both cases no memory read is issued.
- R2: When `msi32_en` is 1 and address bits [63:16] equal 0x0000_0000_FFFF, the request ends with fault code 1. When `msi32_en` is 0, the same address is translated normally.
- R3: `desc_idx` equals `{req_pe, req_addr[59]}`, which is partition×2 + address bit 59.
- R4: A descriptor whose level field (bits [50:48]) is greater than 4 ends with fault code 4.
- R5: A page-size field (bits [42:38]) of 0 selects bypass. If bypass-allowed (bit 51) is 1, the result is address AND 0x0003_FFFF_FFFF_F000, the mask is 0xFFF and the permission is 3, with no memory read. If bit 51 is 0, the request ends with fault code 5.
- R6: In translated mode, a table-size field (bits [47:43]) of 0 ends with fault code 6.
- R7: The walk performs levels+1 reads. The first read uses base = table-address field (bits [37:0]) << 12 and shift = (table size + 8)×levels + (page size + 11). Each read address is base | (((addr >> shift) & (2^(table size + 8) − 1)) << 3). For the next level, the shift drops by table size + 8 and the base becomes the entry with bits [11:0] cleared. Entries are read as big-endian bytes.
- R8: An intermediate entry with bits [1:0] = 00 ends the walk with fault code 7.
- R9: With p = page size + 11, the final entry yields address = entry AND ~(2^p − 1), mask = 2^p − 1 and permission = entry[1:0] (bit 1 write, bit 0 read). A write without bit 1, or a read without bit 0, gives fault code 8 with these fields still reported. Fault code 0 is reported exactly when `fault` is 0.
- R10: An error response from memory ends the walk with fault code 9. All results are 0 in that case.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address are held. Only one read is outstanding at a time.
- R12: `done` is a one-cycle pulse. `busy` is high from acceptance until that pulse. The result outputs stay unchanged until the next request is accepted. After reset, `done`, `fault`, `busy` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when `busy` is low |
| req_addr | input | 64 | Inbound DMA address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_pe | input | PE_W | Partition number of the requester |
| msi32_en | input | 1 | Enables rejection of the 32-bit message window |
| desc_idx | output | PE_W+1 | Index of the window descriptor to present |
| desc_data | input | 52 | Window descriptor at `desc_idx`, same cycle |
| busy | output | 1 | A request is in progress |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 64 | Entry, big-endian byte order |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Request ended in a fault |
| fault_code | output | 4 | Fault cause, 0 when there is none |
| xlt_addr | output | 64 | Translated page address |
| page_mask | output | 64 | Page offset mask |
| perm | output | 2 | Permission: bit 1 write, bit 0 read |

## Verification
The bench targets these corner cases:

- **Window and region edges:** the 32-bit message window with the enable bit both on and off, and address top nibbles 1 and 0xA. A design that skipped a check would issue table reads for a message address.
- **Walk depth:** walks of one, two and three levels with different table and page sizes. An off-by-one in the shift or the level count would read from the wrong slot, which the bench's expected-address queue catches.
- **Entry byte order:** a missing byte swap would turn every entry into garbage.
- **Faults mid-walk:** an invalid intermediate entry, a read-only page hit by a write, and a memory error on the second read. Each must stop the walk with the right code and no further reads.
- **Stalls and holding:** the ready signal stalls one cycle in three, so a request that dropped or changed address while stalled is caught. Results are compared on every idle clock, so outputs that drift after `done` are caught too.

// File: rtl/dxw_pkg.sv
package dxw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_WAIT,
        S_CHECK,
        S_DONE,
        S_FAULT
    } walk_state_e;

    typedef enum logic [3:0] {
        FC_NONE     = 4'd0,
        FC_MSI32    = 4'd1,
        FC_MSI64    = 4'd2,
        FC_UNSUP    = 4'd3,
        FC_LEVELS   = 4'd4,
        FC_BYPASS   = 4'd5,
        FC_TSIZE    = 4'd6,
        FC_INDIRECT = 4'd7,
        FC_ACCESS   = 4'd8,
        FC_MEMERR   = 4'd9
    } fault_code_e;

    // Window descriptor layout (52 bits)
    localparam int DESC_W      = 52;
    localparam int D_BYPASS_OK = 51;
    localparam int D_LEV_HI    = 50;
    localparam int D_LEV_LO    = 48;
    localparam int D_TS_HI     = 47;
    localparam int D_TS_LO     = 43;
    localparam int D_PS_HI     = 42;
    localparam int D_PS_LO     = 38;
    localparam int D_TA_HI     = 37;

    localparam int MAX_LEVELS  = 4;
    localparam int IDX_BIAS    = 8;
    localparam int OFF_BIAS    = 11;
    localparam logic [63:0] BYPASS_KEEP = 64'h0003_FFFF_FFFF_F000;
    localparam logic [47:0] MSI32_TAG   = 48'h0000_0000_FFFF;

endpackage

// File: rtl/dxw_steer.sv
module dxw_steer
    import dxw_pkg::*;
(
    input  logic [63:16] addr_hi,
    input  logic         msi32_en,
    input  logic         bypass_ok,
    input  logic [2:0]   levels,
    input  logic [4:0]   tsize,
    input  logic [4:0]   psize,
    output fault_code_e  code,
    output logic         bypass
);
    always_comb begin
        code   = FC_NONE;
        bypass = 1'b0;
        if (addr_hi[63:60] == 4'h1) begin
            code = FC_MSI64;
        end else if (addr_hi[63:60] != 4'h0) begin
            code = FC_UNSUP;
        end else if (msi32_en && (addr_hi == MSI32_TAG)) begin
            code = FC_MSI32;
        end else if (levels > 3'(MAX_LEVELS)) begin
            code = FC_LEVELS;
        end else if (psize == 5'd0) begin
            if (bypass_ok) bypass = 1'b1;
            else           code   = FC_BYPASS;
        end else if (tsize == 5'd0) begin
            code = FC_TSIZE;
        end
    end
endmodule

// File: rtl/dxw_slot_addr.sv
module dxw_slot_addr (
    input  logic [63:0] addr,
    input  logic [63:0] base,
    input  logic [7:0]  shift,
    input  logic [5:0]  idx_bits,
    output logic [63:0] ent_addr
);
    logic [63:0] shifted;
    logic [63:0] idx_mask;

    always_comb begin
        shifted  = (shift >= 8'd64) ? 64'd0 : (addr >> shift[5:0]);
        idx_mask = (64'd1 << idx_bits) - 64'd1;
        ent_addr = base | ((shifted & idx_mask) << 3);
    end
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
    import dxw_pkg::*;
#(
    parameter int PE_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [63:0]         req_addr,
    input  logic                req_write,
    input  logic [PE_W-1:0]     req_pe,
    input  logic                msi32_en,
    output logic [PE_W:0]       desc_idx,
    input  logic [DESC_W-1:0]   desc_data,
    output logic                busy,
    output logic                mem_req_valid,
    output logic [63:0]         mem_req_addr,
    input  logic                mem_req_ready,
    input  logic                mem_rsp_valid,
    input  logic [63:0]         mem_rsp_data,
    input  logic                mem_rsp_err,
    output logic                done,
    output logic                fault,
    output logic [3:0]          fault_code,
    output logic [63:0]         xlt_addr,
    output logic [63:0]         page_mask,
    output logic [1:0]          perm
);
    walk_state_e state_q, state_d;

    logic [63:0] addr_q, base_q, ent_q, xlt_q, mask_q;
    logic [7:0]  shift_q;
    logic [2:0]  lev_q;
    logic [5:0]  ib_q, ob_q;
    logic        wr_q, fault_q;
    logic [1:0]  perm_q;
    fault_code_e code_q;

    // Descriptor fields
    logic        d_bypass_ok;
    logic [2:0]  d_lev;
    logic [4:0]  d_ts, d_ps;
    logic [37:0] d_ta;
    logic [5:0]  d_ib, d_ob;
    logic [7:0]  sh_init;
    assign d_bypass_ok = desc_data[D_BYPASS_OK];
    assign d_lev       = desc_data[D_LEV_HI:D_LEV_LO];
    assign d_ts        = desc_data[D_TS_HI:D_TS_LO];
    assign d_ps        = desc_data[D_PS_HI:D_PS_LO];
    assign d_ta        = desc_data[D_TA_HI:0];
    assign d_ib        = {1'b0, d_ts} + 6'(IDX_BIAS);
    assign d_ob        = {1'b0, d_ps} + 6'(OFF_BIAS);
    assign sh_init     = 8'(d_ib) * 8'(d_lev) + 8'(d_ob);

    assign desc_idx = {req_pe, req_addr[59]};

    fault_code_e steer_code;
    logic        steer_bypass;

    dxw_steer u_steer (
        .addr_hi   (req_addr[63:16]),
        .msi32_en  (msi32_en),
        .bypass_ok (d_bypass_ok),
        .levels    (d_lev),
        .tsize     (d_ts),
        .psize     (d_ps),
        .code      (steer_code),
        .bypass    (steer_bypass)
    );

    dxw_slot_addr u_slot (
        .addr     (addr_q),
        .base     (base_q),
        .shift    (shift_q),
        .idx_bits (ib_q),
        .ent_addr (mem_req_addr)
    );

    // Big-endian entry to native order
    logic [63:0] rsp_native;
    for (genvar b = 0; b < 8; b++) begin : g_bswap
        assign rsp_native[8*b +: 8] = mem_rsp_data[8*(7-b) +: 8];
    end

    logic        acc_bad, ent_dead, accept, rejected;
    logic [63:0] pg_off;
    assign pg_off   = (64'd1 << ob_q) - 64'd1;
    assign acc_bad  = wr_q ? ~ent_q[1] : ~ent_q[0];
    assign ent_dead = (ent_q[1:0] == 2'b00);
    assign accept   = (state_q == S_IDLE) && req_valid;
    assign rejected = (steer_code != FC_NONE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) begin
                         if (rejected)          state_d = S_FAULT;
                         else if (steer_bypass) state_d = S_DONE;
                         else                   state_d = S_READ;
                     end
            S_READ:  if (mem_req_ready) state_d = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) state_d = mem_rsp_err ? S_FAULT : S_CHECK;
            S_CHECK: if (lev_q != 3'd0) state_d = ent_dead ? S_FAULT : S_READ;
                     else               state_d = acc_bad  ? S_FAULT : S_DONE;
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0; base_q <= '0; ent_q <= '0; shift_q <= '0;
            lev_q <= '0; ib_q <= '0; ob_q <= '0; wr_q <= 1'b0;
            xlt_q <= '0; mask_q <= '0; perm_q <= '0;
            fault_q <= 1'b0; code_q <= FC_NONE;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    addr_q  <= req_addr;
                    wr_q    <= req_write;
                    base_q  <= {14'd0, d_ta, 12'd0};
                    shift_q <= sh_init;
                    lev_q   <= d_lev;
                    ib_q    <= d_ib;
                    ob_q    <= d_ob;
                    fault_q <= rejected;
                    code_q  <= steer_code;
                    if (!rejected && steer_bypass) begin
                        xlt_q  <= req_addr & BYPASS_KEEP;
                        mask_q <= 64'hFFF;
                        perm_q <= 2'b11;
                    end else begin
                        xlt_q  <= '0;
                        mask_q <= '0;
                        perm_q <= '0;
                    end
                end
                S_WAIT: if (mem_rsp_valid) begin
                    ent_q <= rsp_native;
                    if (mem_rsp_err) begin
                        fault_q <= 1'b1;
                        code_q  <= FC_MEMERR;
                    end
                end
                S_CHECK: begin
                    if (lev_q != 3'd0) begin
                        if (ent_dead) begin
                            fault_q <= 1'b1;
                            code_q  <= FC_INDIRECT;
                        end else begin
                            base_q  <= {ent_q[63:12], 12'd0};
                            shift_q <= shift_q - 8'(ib_q);
                            lev_q   <= lev_q - 3'd1;
                        end
                    end else begin
                        xlt_q  <= ent_q & ~pg_off;
                        mask_q <= pg_off;
                        perm_q <= ent_q[1:0];
                        if (acc_bad) begin
                            fault_q <= 1'b1;
                            code_q  <= FC_ACCESS;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy          = (state_q != S_IDLE);
    assign mem_req_valid = (state_q == S_READ);
    assign done          = (state_q == S_DONE) || (state_q == S_FAULT);
    assign fault         = fault_q;
    assign fault_code    = code_q;
    assign xlt_addr      = xlt_q;
    assign page_mask     = mask_q;
    assign perm          = perm_q;

    // R11: a stalled read keeps its request and address
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R12: completion is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: results hold while idle and no request arrives
    p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> ($stable(xlt_addr) && $stable(page_mask)
                                   && $stable(perm) && $stable(fault) && $stable(fault_code)));

    // R1: a nonzero top nibble ends in a fault on the next cycle, without a read
    p_steer_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_addr[63:60] != 4'h0)) |=> (done && fault && !mem_req_valid));

    // R5: bypass completes without a memory read
    p_bypass_nomem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && steer_bypass && !rejected) |=> (done && !mem_req_valid));

    // R9: fault flag and fault code agree at completion
    p_code_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault == (fault_code != 4'd0)));

    // R9: a successful walk grants the permission the access needed
    p_perm_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (wr_q ? perm[1] : perm[0]));

endmodule

// File: tb/dma_xlate_walker_tb.sv
module dma_xlate_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PE_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [PE_W-1:0] req_pe = '0;
    logic msi32_en = 1'b0;
    logic [PE_W:0] desc_idx;
    logic [51:0] desc_data;
    logic busy, mem_req_valid;
    logic [63:0] mem_req_addr;
    logic mem_req_ready, mem_rsp_valid, mem_rsp_err;
    logic [63:0] mem_rsp_data;
    logic done, fault;
    logic [3:0] fault_code;
    logic [63:0] xlt_addr, page_mask;
    logic [1:0] perm;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [51:0] desc_tab [0:(1<<(PE_W+1))-1];
    assign desc_data = desc_tab[desc_idx];

    dma_xlate_walker #(.PE_W(PE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_pe(req_pe), .msi32_en(msi32_en),
        .desc_idx(desc_idx), .desc_data(desc_data), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done(done), .fault(fault), .fault_code(fault_code),
        .xlt_addr(xlt_addr), .page_mask(page_mask), .perm(perm)
    );

    int vectors = 0;
    int fails = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Table memory, logical (native) entry values
    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_q [$];
    int err_read = 0;
    int rd_no = 0;

    function automatic logic [63:0] mem_rd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] bswap(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] slot(input logic [63:0] base, input logic [63:0] a,
                                         input int sh, input int ib);
        logic [63:0] s;
        s = (sh >= 64) ? 64'd0 : (a >> sh);
        return base | ((s & ((64'd1 << ib) - 64'd1)) << 3);
    endfunction

    function automatic logic [51:0] mk_desc(input bit bp, input int lev, input int ts,
                                            input int ps, input logic [37:0] ta);
        return {bp, 3'(lev), 5'(ts), 5'(ps), ta};
    endfunction

    // Reference model expectations
    logic        exp_fault;
    int          exp_code;
    logic [63:0] exp_xlt, exp_mask;
    logic [1:0]  exp_perm;
    logic        held_fault = 1'b0;
    int          held_code = 0;
    logic [63:0] held_xlt = '0, held_mask = '0;
    logic [1:0]  held_perm = '0;
    bit          mon_on = 1'b0;

    function automatic void ref_model(input logic [63:0] a, input bit wr,
                                      input logic [51:0] d, input bit m32);
        int lev, ts, ps, ib, ob, sh, k;
        logic [63:0] base, ent, ta;
        exp_fault = 1'b1; exp_code = 0; exp_xlt = '0; exp_mask = '0; exp_perm = '0;
        exp_q.delete();
        lev = int'(d[50:48]); ts = int'(d[47:43]); ps = int'(d[42:38]);
        if (a[63:60] == 4'h1) begin exp_code = 2; return; end
        if (a[63:60] != 4'h0) begin exp_code = 3; return; end
        if (m32 && a[63:16] == 48'h0000_0000_FFFF) begin exp_code = 1; return; end
        if (lev > 4) begin exp_code = 4; return; end
        if (ps == 0) begin
            if (!d[51]) begin exp_code = 5; return; end
            exp_fault = 1'b0;
            exp_xlt = a & 64'h0003_FFFF_FFFF_F000;
            exp_mask = 64'hFFF; exp_perm = 2'b11;
            return;
        end
        if (ts == 0) begin exp_code = 6; return; end
        ib = ts + 8; ob = ps + 11;
        sh = ib * lev + ob;
        base = {26'd0, d[37:0]} << 12;
        k = 0;
        for (int l = lev; l >= 0; l--) begin
            ta = slot(base, a, sh, ib);
            exp_q.push_back(ta);
            k++;
            if (k == err_read) begin exp_code = 9; return; end
            ent = mem_rd(ta);
            if (l > 0) begin
                if (ent[1:0] == 2'b00) begin exp_code = 7; return; end
                sh = sh - ib;
                base = ent & ~64'hFFF;
            end else begin
                exp_mask = (64'd1 << ob) - 64'd1;
                exp_xlt = ent & ~exp_mask;
                exp_perm = ent[1:0];
                if ((wr && !ent[1]) || (!wr && !ent[0])) exp_code = 8;
                else exp_fault = 1'b0;
            end
        end
    endfunction

    // Memory responder: ready stalls one cycle in three, one-cycle latency
    int cyc = 0;
    bit pend = 1'b0;
    logic [63:0] pend_addr = '0;
    bit prev_stall = 1'b0;
    logic [63:0] prev_addr = '0;
    initial begin
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = bswap(mem_rd(pend_addr));
                mem_rsp_err   = (rd_no == err_read);
                pend = 1'b0;
            end
            if (prev_stall) begin
                chk("R11 held request", {63'd0, mem_req_valid}, 64'd1);
                chk("R11 stable address", mem_req_addr, prev_addr);
            end
            mem_req_ready = (cyc % 3) != 0;
            if (mem_req_valid && mem_req_ready) begin
                rd_no++;
                if (exp_q.size() == 0) chk("R7 unexpected read", mem_req_addr, 64'hX);
                else chk("R7 entry address", mem_req_addr, exp_q.pop_front());
                pend = 1'b1;
                pend_addr = mem_req_addr;
            end
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_addr  = mem_req_addr;
        end
    end

    // Every-clock comparison of held results and the done pulse
    bit prev_done = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_done && done) chk("R12 done pulse width", 64'd2, 64'd1);
                if (mon_on && !busy) begin
                    chk("R12 held fault", {63'd0, fault}, {63'd0, held_fault});
                    chk("R12 held code", {60'd0, fault_code}, 64'(held_code));
                    chk("R12 held address", xlt_addr, held_xlt);
                    chk("R12 held mask", page_mask, held_mask);
                    chk("R12 held perm", {62'd0, perm}, {62'd0, held_perm});
                end
            end
            prev_done = done;
        end
    end

    task automatic xlate(input string req, input logic [63:0] a, input bit wr,
                         input int pe, input bit m32);
        int waited;
        mon_on = 1'b0;
        rd_no = 0;
        ref_model(a, wr, desc_tab[{6'(pe), a[59]}], m32);
        @(negedge clk);
        msi32_en = m32; req_addr = a; req_write = wr; req_pe = PE_W'(pe); req_valid = 1'b1;
        #1;
        chk("R3 descriptor index", 64'(desc_idx), 64'(pe * 2 + int'(a[59])));
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!done && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        if (!done) chk({req, " watchdog"}, 64'd0, 64'd1);
        chk({req, " fault"}, {63'd0, fault}, {63'd0, exp_fault});
        chk({req, " code"}, {60'd0, fault_code}, 64'(exp_code));
        chk({req, " address"}, xlt_addr, exp_xlt);
        chk({req, " mask"}, page_mask, exp_mask);
        chk({req, " perm"}, {62'd0, perm}, {62'd0, exp_perm});
        chk("R7 read count", 64'(exp_q.size()), 64'd0);
        held_fault = exp_fault; held_code = exp_code; held_xlt = exp_xlt;
        held_mask = exp_mask; held_perm = exp_perm;
        @(negedge clk);
        mon_on = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Global watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        vectors++;
        $display("FAIL R12 global watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [63:0] a;
        for (int i = 0; i < (1 << (PE_W + 1)); i++) desc_tab[i] = '0;
        repeat (3) @(negedge clk);
        chk("R12 reset done", {63'd0, done}, 64'd0);
        chk("R12 reset busy", {63'd0, busy}, 64'd0);
        chk("R12 reset fault", {63'd0, fault}, 64'd0);
        chk("R12 reset read", {63'd0, mem_req_valid}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 region steering
        desc_tab[{6'd2, 1'b0}] = mk_desc(1, 0, 0, 0, 38'd0);
        desc_tab[{6'd2, 1'b1}] = mk_desc(1, 0, 0, 0, 38'd0);
        xlate("R1 msi64", 64'h1000_0000_0000_1000, 0, 2, 0);
        xlate("R1 unsupported", 64'hA000_0000_0000_1000, 0, 2, 0);

        // R2 32-bit message window; R5 bypass
        xlate("R2 msi32 rejected", 64'h0000_0000_FFFF_1234, 0, 2, 1);
        xlate("R2 msi32 disabled", 64'h0000_0000_FFFF_1234, 1, 2, 0);
        xlate("R5 bypass", 64'h0F12_3456_789A_BCDE, 1, 2, 1);
        desc_tab[{6'd4, 1'b0}] = mk_desc(0, 0, 1, 0, 38'd0);
        xlate("R5 bypass disallowed", 64'h0000_0000_0000_5000, 0, 4, 0);

        // R4 and R6 descriptor checks
        desc_tab[{6'd5, 1'b0}] = mk_desc(1, 5, 1, 1, 38'h100);
        xlate("R4 too many levels", 64'h0000_0000_0000_5000, 0, 5, 0);
        desc_tab[{6'd6, 1'b0}] = mk_desc(1, 1, 0, 1, 38'h100);
        xlate("R6 zero table size", 64'h0000_0000_0000_5000, 0, 6, 0);

        // R7/R9 single level
        desc_tab[{6'd1, 1'b0}] = mk_desc(0, 0, 1, 1, 38'h100);
        a = 64'h0000_0000_1234_5678;
        mem[slot(64'h100000, a, 12, 9)] = 64'h0000_0012_3450_0001;
        xlate("R9 one level read", a, 0, 1, 0);
        xlate("R9 write to read-only", a, 1, 1, 0);

        // R7 two levels, partition 3 with bit 59 set
        desc_tab[{6'd3, 1'b1}] = mk_desc(0, 1, 1, 1, 38'h200);
        a = 64'h0800_0000_0ABC_D123;
        mem[slot(64'h200000, a, 21, 9)] = 64'h0000_0000_0030_0003;
        mem[slot(64'h300000, a, 12, 9)] = 64'h0000_00AB_CDEF_1003;
        xlate("R7 two level write", a, 1, 3, 0);

        // R10 memory error on second read
        err_read = 2;
        xlate("R10 memory error", a, 0, 3, 0);
        err_read = 0;

        // R7 three levels, larger table and page
        desc_tab[{6'd7, 1'b0}] = mk_desc(0, 2, 2, 4, 38'h400);
        a = 64'h0000_0123_4567_89AB;
        mem[slot(64'h400000, a, 35, 10)] = 64'h0000_0000_0050_0001;
        mem[slot(64'h500000, a, 25, 10)] = 64'h0000_0000_0060_0002;
        mem[slot(64'h600000, a, 15, 10)] = 64'h0000_0077_7777_F001;
        xlate("R7 three level read", a, 0, 7, 0);
        xlate("R9 three level write fault", a, 1, 7, 0);

        // R8 invalid intermediate entry
        desc_tab[{6'd8, 1'b0}] = mk_desc(0, 1, 1, 1, 38'h210);
        a = 64'h0000_0000_0123_4000;
        mem[slot(64'h210000, a, 21, 9)] = 64'h0000_0000_0070_0000;
        xlate("R8 invalid intermediate", a, 0, 8, 0);

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule